// File: doc/BRIEF.md
# ATA Device Readiness Qualifier

This block stands between a host-side command sequencer and the register bus of a parallel ATA channel. When the sequencer asks for a drive, the block works out whether that drive can be trusted to be ready, is still busy, has failed, or has not answered in time. It keeps a copy of the last drive/head byte it wrote. If a request names the same drive, the block skips the register write and the settle delay. If the request names a different drive, or the copy is invalid, the block writes the drive/head register. It then throws away a fixed run of status reads so the newly selected device has time to drive the bus.

Polling uses the alternate status register, so a pending interrupt is never cleared. A request can flag that a command byte has just been written. In that case the error and device-fault bits are ignored for the first few status reads, because they may still describe the previous command. There are two wait modes. Data mode waits for the device to request a data transfer. Non-data mode completes as soon as the device stops being busy. A free-running cycle count per request, measured against a programmable limit, turns a hung device into a timeout result.

Top module: `ata_wait_qual`

## Requirements
- R1: A synchronous active-high reset leaves `busy` and `done` low with no bus strobe, and invalidates the select cache, so the first accepted request always performs a real select.
- R2: When the requested drive/head byte (0xE0 for drive 0, 0xF0 for drive 1) differs from the cached one, the first busy cycle writes it to command-block offset 6. The next 14 cycles are discarded alternate-status reads, and the first judged read falls in busy cycle 15.
- R3: When the requested byte equals the cached one, no write is made and the very first status read (busy cycle 0) is judged.
- R4: In data mode, a judged read with bit 7 (BSY) clear and bit 3 (DRQ) set, and no visible error, finishes with result code 0 (data ready).
- R5: A judged read with BSY clear and bit 0 (ERR) or bit 5 (DF) set finishes with result code 2 (error). This takes priority over DRQ and over non-data completion.
- R6: While BSY is set in a read, every other status bit is ignored and polling continues.
- R7: When the request's command-issued flag is set, ERR and DF are ignored for the first 4 status reads of that request, counting discarded settle reads.
- R8: Every status read targets control-block offset 0 (alternate status); no status read touches the command block, and a read and a write never share a cycle.
- R9: If no result is reached by busy cycle `timeout_limit`, the request finishes with result code 3 (timeout), and `elapsed` then equals `timeout_limit`.
- R10: In non-data mode, a judged read with BSY clear and no visible error finishes with result code 1 (idle ready), whatever DRQ is.
- R11: `done` is a one-cycle pulse in the cycle after the deciding edge. `result` and `elapsed` hold until the next accepted request, and requests raised while `busy` is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Start request, taken only while idle |
| req_drive | input | 1 | Drive number to qualify |
| req_cmd_issued | input | 1 | A command byte was just written; mask stale error bits |
| req_nodata | input | 1 | 1: finish on BSY clear alone; 0: wait for DRQ |
| timeout_limit | input | TIMER_W | Busy cycle index at which an unresolved request times out |
| bus_ctrl_sel | output | 1 | 1: control block, 0: command block |
| bus_ofs | output | 3 | Register offset within the selected block |
| bus_rd | output | 1 | Register read strobe; data sampled on the same edge |
| bus_wr | output | 1 | Register write strobe |
| bus_wdata | output | 8 | Write data |
| bus_rdata | input | 8 | Read data, valid while `bus_rd` is high |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 2 | 0 data ready, 1 idle ready, 2 error, 3 timeout |
| elapsed | output | TIMER_W | Busy cycle index of the deciding read |

## Verification
The bench targets the cache boundary: the first request after reset, a repeat of the same drive, and a switch of drive. A design that compared against a stale or uninitialised copy would either skip the needed select, or pay 15 cycles and a bus write on every request, and both show up in the write count and in `elapsed`. It also checks the stale-error window by placing ERR alone and ERR with DRQ inside the first four reads. A design that judged too early would report an error where a data-ready result is due, and one that masked too long would finish late. Finally, it feeds BSY together with every other bit set, to show that error and DRQ bits seen under BSY neither end nor steer the wait. Only the programmed timeout may then finish the request, in exactly its limit cycle.

// File: rtl/ata_wait_pkg.sv
package ata_wait_pkg;

    localparam logic [7:0] STS_BSY = 8'h80;
    localparam logic [7:0] STS_DRQ = 8'h08;
    localparam logic [7:0] STS_ERR = 8'h01;
    localparam logic [7:0] STS_DF  = 8'h20;

    localparam logic [2:0] OFS_DEVHEAD = 3'd6;
    localparam logic [2:0] OFS_ALTSTS  = 3'd0;

    typedef enum logic [1:0] {
        RES_DATA    = 2'd0,
        RES_IDLE    = 2'd1,
        RES_ERROR   = 2'd2,
        RES_TIMEOUT = 2'd3
    } wait_result_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_SELECT,
        PH_SETTLE,
        PH_POLL
    } wait_phase_e;

    typedef enum logic [1:0] {
        VD_WAIT,
        VD_DATA,
        VD_IDLE,
        VD_ERROR
    } verdict_e;

    typedef struct packed {
        logic       ctrl_sel;
        logic [2:0] ofs;
        logic       rd;
        logic       wr;
        logic [7:0] wdata;
    } bus_cmd_t;

    // LBA addressing with both legacy bits set; drive number in bit 4
    function automatic logic [7:0] devhead_value(input logic drive);
        return 8'hE0 | {3'b000, drive, 4'b0000};
    endfunction

    function automatic wait_result_e verdict_to_result(input verdict_e v);
        case (v)
            VD_DATA:  return RES_DATA;
            VD_IDLE:  return RES_IDLE;
            VD_ERROR: return RES_ERROR;
            default:  return RES_TIMEOUT;
        endcase
    endfunction

endpackage

// File: rtl/ata_select_cache.sv
module ata_select_cache
    import ata_wait_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] probe_val,
    output logic       hit,
    input  logic       load,
    input  logic [7:0] load_val
);
    logic       valid_q;
    logic [7:0] value_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            value_q <= '0;
        end else if (load) begin
            valid_q <= 1'b1;
            value_q <= load_val;
        end
    end

    assign hit = valid_q && (value_q == probe_val);

endmodule

// File: rtl/ata_wait_timer.sv
module ata_wait_timer #(
    parameter int TIMER_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               clear,
    input  logic               run,
    input  logic [TIMER_W-1:0] limit,
    output logic [TIMER_W-1:0] count,
    output logic               expired
);
    localparam logic [TIMER_W-1:0] CNT_MAX = '1;

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (clear) begin
            count <= '0;
        end else if (run && count != CNT_MAX) begin
            count <= count + 1'b1;
        end
    end

    assign expired = (count >= limit);

endmodule

// File: rtl/ata_status_judge.sv
module ata_status_judge
    import ata_wait_pkg::*;
(
    input  logic [7:0] status,
    input  logic       mask_err,
    input  logic       nodata,
    output verdict_e   verdict
);
    logic bsy, drq, fault;

    always_comb begin
        bsy   = (status & STS_BSY) != 8'h00;
        drq   = (status & STS_DRQ) != 8'h00;
        fault = (status & (STS_ERR | STS_DF)) != 8'h00;
        if (bsy)
            verdict = VD_WAIT;
        else if (fault && !mask_err)
            verdict = VD_ERROR;
        else if (nodata)
            verdict = VD_IDLE;
        else if (drq)
            verdict = VD_DATA;
        else
            verdict = VD_WAIT;
    end

endmodule

// File: rtl/ata_wait_qual.sv
module ata_wait_qual
    import ata_wait_pkg::*;
#(
    parameter int TIMER_W      = 16,
    parameter int SETTLE_READS = 15,
    parameter int STALE_READS  = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic               req_drive,
    input  logic               req_cmd_issued,
    input  logic               req_nodata,
    input  logic [TIMER_W-1:0] timeout_limit,
    output logic               bus_ctrl_sel,
    output logic [2:0]         bus_ofs,
    output logic               bus_rd,
    output logic               bus_wr,
    output logic [7:0]         bus_wdata,
    input  logic [7:0]         bus_rdata,
    output logic               busy,
    output logic               done,
    output logic [1:0]         result,
    output logic [TIMER_W-1:0] elapsed
);
    localparam int SLW = $clog2(SETTLE_READS + 1);
    localparam int STW = $clog2(STALE_READS + 1);
    localparam logic [SLW-1:0] SETTLE_LOAD = SLW'(SETTLE_READS - 1);
    localparam logic [STW-1:0] STALE_LOAD  = STW'(STALE_READS);
    localparam bit HAS_SETTLE = (SETTLE_READS > 1);

    wait_phase_e    phase_q;
    logic           drive_q;
    logic           nodata_q;
    logic [STW-1:0] stale_left_q;
    logic [SLW-1:0] settle_left_q;
    wait_result_e   result_q;
    logic           done_q;

    bus_cmd_t  bus_cmd;
    verdict_e  verdict;
    logic      accept, cache_hit, timer_expired;
    logic      finish_judged, finish_timeout, finish;
    logic [7:0] probe_val;

    assign probe_val = devhead_value(req_drive);
    assign accept    = req_valid && (phase_q == PH_IDLE);

    ata_select_cache u_cache (
        .clk       (clk),
        .rst       (rst),
        .probe_val (probe_val),
        .hit       (cache_hit),
        .load      (phase_q == PH_SELECT),
        .load_val  (devhead_value(drive_q))
    );

    ata_wait_timer #(.TIMER_W(TIMER_W)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .clear   (accept),
        .run     ((phase_q != PH_IDLE) && !finish),
        .limit   (timeout_limit),
        .count   (elapsed),
        .expired (timer_expired)
    );

    ata_status_judge u_judge (
        .status   (bus_rdata),
        .mask_err (stale_left_q != '0),
        .nodata   (nodata_q),
        .verdict  (verdict)
    );

    always_comb begin
        bus_cmd = '0;
        case (phase_q)
            PH_SELECT: begin
                bus_cmd.wr    = 1'b1;
                bus_cmd.ofs   = OFS_DEVHEAD;
                bus_cmd.wdata = devhead_value(drive_q);
            end
            PH_SETTLE, PH_POLL: begin
                bus_cmd.rd       = 1'b1;
                bus_cmd.ctrl_sel = 1'b1;
                bus_cmd.ofs      = OFS_ALTSTS;
            end
            default: ;
        endcase
    end

    assign finish_judged  = (phase_q == PH_POLL) && (verdict != VD_WAIT);
    assign finish_timeout = (phase_q != PH_IDLE) && !finish_judged && timer_expired;
    assign finish         = finish_judged || finish_timeout;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q       <= PH_IDLE;
            drive_q       <= 1'b0;
            nodata_q      <= 1'b0;
            settle_left_q <= '0;
            result_q      <= RES_DATA;
            done_q        <= 1'b0;
        end else begin
            done_q <= finish;
            if (accept) begin
                drive_q  <= req_drive;
                nodata_q <= req_nodata;
                phase_q  <= cache_hit ? PH_POLL : PH_SELECT;
            end else if (finish) begin
                phase_q  <= PH_IDLE;
                result_q <= finish_judged ? verdict_to_result(verdict) : RES_TIMEOUT;
            end else begin
                case (phase_q)
                    PH_SELECT: begin
                        settle_left_q <= SETTLE_LOAD;
                        phase_q       <= HAS_SETTLE ? PH_SETTLE : PH_POLL;
                    end
                    PH_SETTLE: begin
                        settle_left_q <= settle_left_q - 1'b1;
                        if (settle_left_q <= SLW'(1))
                            phase_q <= PH_POLL;
                    end
                    default: ;
                endcase
            end
        end
    end

    // stale-error window: loaded per request, spent one per status read
    always_ff @(posedge clk) begin
        if (rst)
            stale_left_q <= '0;
        else if (accept)
            stale_left_q <= req_cmd_issued ? STALE_LOAD : '0;
        else if (bus_cmd.rd && stale_left_q != '0)
            stale_left_q <= stale_left_q - 1'b1;
    end

    assign bus_ctrl_sel = bus_cmd.ctrl_sel;
    assign bus_ofs      = bus_cmd.ofs;
    assign bus_rd       = bus_cmd.rd;
    assign bus_wr       = bus_cmd.wr;
    assign bus_wdata    = bus_cmd.wdata;
    assign busy         = (phase_q != PH_IDLE);
    assign done         = done_q;
    assign result       = result_q;

endmodule

// File: rtl/ata_wait_qual_chk.sv
module ata_wait_qual_chk #(
    parameter int TIMER_W = 16
) (
    input logic               clk,
    input logic               rst,
    input logic               req_valid,
    input logic [TIMER_W-1:0] timeout_limit,
    input logic               bus_ctrl_sel,
    input logic [2:0]         bus_ofs,
    input logic               bus_rd,
    input logic               bus_wr,
    input logic [7:0]         bus_wdata,
    input logic [7:0]         bus_rdata,
    input logic               busy,
    input logic               done,
    input logic [1:0]         result,
    input logic [TIMER_W-1:0] elapsed
);
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R11

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy); // R11

    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (rst)
        (!busy && !done && !req_valid) |=> $stable(result)); // R11

    AST_RD_ALTSTS: assert property (@(posedge clk) disable iff (rst)
        bus_rd |-> (bus_ctrl_sel && bus_ofs == 3'd0 && !bus_wr)); // R8

    AST_WR_DEVHEAD: assert property (@(posedge clk) disable iff (rst)
        bus_wr |-> (!bus_ctrl_sel && bus_ofs == 3'd6 && (bus_wdata & 8'hEF) == 8'hE0)); // R2

    AST_STROBE_BUSY: assert property (@(posedge clk) disable iff (rst)
        (bus_rd || bus_wr) |-> busy); // R1

    AST_BSY_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_rdata[7] && elapsed < timeout_limit) |=> !done); // R6

    AST_TIMEOUT_AT_LIMIT: assert property (@(posedge clk) disable iff (rst)
        (done && result == 2'd3) |-> (elapsed == timeout_limit)); // R9
endmodule

bind ata_wait_qual ata_wait_qual_chk #(.TIMER_W(TIMER_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .req_valid     (req_valid),
    .timeout_limit (timeout_limit),
    .bus_ctrl_sel  (bus_ctrl_sel),
    .bus_ofs       (bus_ofs),
    .bus_rd        (bus_rd),
    .bus_wr        (bus_wr),
    .bus_wdata     (bus_wdata),
    .bus_rdata     (bus_rdata),
    .busy          (busy),
    .done          (done),
    .result        (result),
    .elapsed       (elapsed)
);

// File: tb/ata_wait_qual_test.sv
`timescale 1ns/1ps
module ata_wait_qual_test;
    localparam int TW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_drive = 1'b0;
    logic          req_cmd_issued = 1'b0;
    logic          req_nodata = 1'b0;
    logic [TW-1:0] timeout_limit = 16'd1000;
    logic          bus_ctrl_sel, bus_rd, bus_wr;
    logic [2:0]    bus_ofs;
    logic [7:0]    bus_wdata, bus_rdata;
    logic          busy, done;
    logic [1:0]    result;
    logic [TW-1:0] elapsed;

    int   checks = 0;
    int   errors = 0;
    bit   finished = 1'b0;

    int   rd_count = 0;
    int   wr_count = 0;
    int   bad_acc  = 0;
    logic [7:0] last_wr = 8'h00;
    int   busy_reads = 0;
    logic [7:0] final_status = 8'h00;

    always #4 clk = ~clk;

    ata_wait_qual #(.TIMER_W(TW)) uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_drive(req_drive),
        .req_cmd_issued(req_cmd_issued), .req_nodata(req_nodata),
        .timeout_limit(timeout_limit), .bus_ctrl_sel(bus_ctrl_sel),
        .bus_ofs(bus_ofs), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .busy(busy),
        .done(done), .result(result), .elapsed(elapsed)
    );

    // device model: BSY with every other bit set, then the final status
    assign bus_rdata = (rd_count < busy_reads) ? 8'hA9 : final_status;

    always @(posedge clk) begin
        if (rst || (req_valid && !busy)) begin
            rd_count <= 0;
            wr_count <= 0;
        end else begin
            if (bus_rd) rd_count <= rd_count + 1;
            if (bus_wr) begin
                wr_count <= wr_count + 1;
                last_wr  <= bus_wdata;
            end
        end
        if (bus_rd && !(bus_ctrl_sel && bus_ofs == 3'd0)) bad_acc <= bad_acc + 1;
        if (bus_wr && !(!bus_ctrl_sel && bus_ofs == 3'd6)) bad_acc <= bad_acc + 1;
        if (bus_rd && bus_wr) bad_acc <= bad_acc + 1;
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1", "busy after reset", int'(busy), 0);
        check("R1", "done after reset", int'(done), 0);
        check("R1", "strobes after reset", int'(bus_rd) + int'(bus_wr), 0);
    endtask

    task automatic run_op(input string req, input bit drv, input bit cmd, input bit nodata,
                          input int b, input logic [7:0] fin, input int exp_wr,
                          input int exp_res, input int exp_el, input bit poke);
        int waited;
        logic [1:0] res_seen;
        busy_reads   = b;
        final_status = fin;
        @(negedge clk);
        req_valid = 1'b1; req_drive = drv; req_cmd_issued = cmd; req_nodata = nodata;
        @(negedge clk);
        req_valid = 1'b0;
        waited = 0;
        while (!done && waited < 5000) begin
            if (poke && waited == 1) begin
                req_valid = 1'b1; req_drive = ~drv;
            end else begin
                req_valid = 1'b0;
            end
            @(negedge clk);
            waited++;
        end
        req_valid = 1'b0;
        check(req, "done seen", int'(done), 1);
        check(req, "result", int'(result), exp_res);
        check(req, "elapsed", int'(elapsed), exp_el);
        check(req, "select writes", wr_count, exp_wr);
        if (exp_wr > 0) check(req, "select value", int'(last_wr), drv ? 8'hF0 : 8'hE0);
        check("R8", "bad bus accesses", bad_acc, 0);
        res_seen = result;
        @(negedge clk);
        check("R11", "done width", int'(done), 0);
        repeat (2) @(negedge clk);
        check("R11", "result held", int'(result), int'(res_seen));
        check("R11", "idle after done", int'(busy), 0);
    endtask

    initial begin
        do_reset();
        // R1 R2 R4: first request after reset must select
        run_op("R2", 1'b0, 1'b0, 1'b0, 0, 8'h58, 1, 0, 15, 1'b0);
        // R3 R6: same drive, skip select, BSY masks other bits
        run_op("R3", 1'b0, 1'b0, 1'b0, 3, 8'h48, 0, 0, 3, 1'b0);
        // R2 R10: drive switch, non-data mode completes on BSY clear
        run_op("R10", 1'b1, 1'b0, 1'b1, 20, 8'h50, 1, 1, 21, 1'b0);
        // R7 R5: ERR masked for four reads, then reported
        run_op("R7", 1'b1, 1'b1, 1'b0, 0, 8'h41, 0, 2, 4, 1'b0);
        // R5: device fault without command flag
        run_op("R5", 1'b1, 1'b0, 1'b0, 0, 8'h60, 0, 2, 0, 1'b0);
        // R7: masked ERR with DRQ gives data ready
        run_op("R7", 1'b1, 1'b1, 1'b0, 0, 8'h49, 0, 0, 0, 1'b0);
        // R5: ERR wins over DRQ when not masked
        run_op("R5", 1'b1, 1'b0, 1'b0, 0, 8'h09, 0, 2, 0, 1'b0);
        // R5: error wins over non-data completion
        run_op("R5", 1'b1, 1'b0, 1'b1, 0, 8'h41, 0, 2, 0, 1'b0);
        // R9 R6: device stays busy
        @(negedge clk);
        timeout_limit = 16'd10;
        run_op("R9", 1'b1, 1'b0, 1'b0, 100000, 8'h48, 0, 3, 10, 1'b0);
        @(negedge clk);
        timeout_limit = 16'd1000;
        // R11: request raised while busy is ignored
        run_op("R11", 1'b1, 1'b0, 1'b0, 5, 8'h48, 0, 0, 5, 1'b1);
        check("R11", "no extra write", wr_count, 0);
        // R1: reset invalidates cache
        do_reset();
        run_op("R1", 1'b1, 1'b0, 1'b0, 0, 8'h48, 1, 0, 15, 1'b0);
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule